// File: doc/BRIEF.md
# PCI Burst Master Sequencer

This block is the initiator half of a 32-bit PCI-style bus master. A local DMA engine hands it a start address, a beat count and a direction. The sequencer requests the bus, waits for a grant, and drives an address phase that carries the memory read or memory write command. It then runs data phases until the whole count has moved. No burst length is fixed. A transaction ends only for three reasons: the count runs out, the target signals STOP#, or the grant has been withdrawn and the latency timer has run down. After an early ending the sequencer asks for the bus again on its own and resumes at the next address.

The bus uses split input and output signals instead of tristate pins, with an output enable for the AD lines. Write data is taken from a local source. A pop strobe is raised on each completed beat. Read data passes straight through with a valid strobe on each completed beat, so it can feed a FIFO. A demand input gates bus requests, which lets the local buffer hold off arbitration until it has data or space. Parity, target-side decoding and configuration space belong to other blocks.

Top module: `pbm_master`

## Requirements
- R1: While reset is held, and on leaving it, req_no, frame_no and irdy_no are high, ad_oe_o is low, and busy_o and done_o are low.
- R2: A beat completes only at a clock edge where irdy_no and trdy_ni are both low. In wait states (trdy_ni high) the address, the remaining count, wr_pop_o and rd_valid_o do not advance.
- R3: While the grant stays asserted, one transaction carries every beat of the transfer, whatever the latency timer value.
- R4: The latency timer loads lat_timer_i when the address phase begins and counts down once per clock. If the grant is deasserted when the timer reaches zero, the next data phase is the final one. With TRDY# low on every cycle and the grant removed during the address phase, a tenure carries lat_timer_i+1 beats for lat_timer_i of 1 or more.
- R5: A target STOP# makes the following data phase final. A phase with STOP# and TRDY# both low counts as a beat. A final phase ended by STOP# with TRDY# high moves no data.
- R6: If beats remain after an early ending, req_no is driven low again after the turnaround cycle. The next address phase carries the address of the first beat not yet moved, so a phase retried without data repeats its address.
- R7: In the address phase cbe_o is 4'b0110 for a read and 4'b0111 for a write, and ad_o carries the beat address. In data phases cbe_o is 4'b0000. ad_oe_o is high in the address phase and in write data phases, and low in read data phases.
- R8: frame_no goes high only while irdy_no is low, marking the final data phase. req_no goes high together with it. irdy_no goes high after that phase completes, and is followed by one cycle in which frame_no, irdy_no and req_no are high and ad_oe_o is low.
- R9: For a one-beat transfer, frame_no is already high in the first cycle in which irdy_no is low.
- R10: req_no goes low only while dreq_i is high. With dreq_i low, a started transfer waits without requesting the bus.
- R11: done_o pulses for one cycle after the last turnaround, and busy_o is low from then on. A start with a zero count pulses done_o one cycle later without touching the bus.
- R12: For a read, rd_valid_o is high exactly on completed beats, with rd_data_o equal to ad_i. For a write, wr_pop_o is high exactly on completed beats, with ad_o equal to wr_data_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a transfer while idle |
| start_addr_i | input | 32 | Byte address of the first beat, word aligned |
| beat_count_i | input | 32 | Number of 32-bit beats to move |
| write_i | input | 1 | 1 for memory write, 0 for memory read |
| dreq_i | input | 1 | Local demand; bus is requested only while high |
| lat_timer_i | input | 8 | Latency timer reload value |
| wr_data_i | input | 32 | Next write beat from the local source |
| wr_pop_o | output | 1 | Write beat accepted this cycle |
| rd_data_o | output | 32 | Read beat data |
| rd_valid_o | output | 1 | Read beat accepted this cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the transfer finishes |
| req_no | output | 1 | Bus request, active low |
| gnt_ni | input | 1 | Bus grant, active low |
| frame_no | output | 1 | Transaction frame, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| trdy_ni | input | 1 | Target ready, active low |
| stop_ni | input | 1 | Target stop, active low |
| ad_o | output | 32 | Address / write data out |
| ad_i | input | 32 | Read data in |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| cbe_o | output | 4 | Command in address phase, byte enables in data phases |

## Verification
The embedded assertions check, on every cycle, the signal-level rules. FRAME# releases only during a data phase. The turnaround cycle is clean. A command code appears at each frame start. Requests follow the demand input. Pops happen only on completed beats. Counters hold still on wait states and never go below zero. The latency timer loads its value. Only the directed scenarios can show how many beats each tenure carries, where it ends after a grant loss or a disconnect, and which address resumes after a retry. The same holds for the write and read data sequences and the timing of the done pulse.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } pbm_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] BE_ALL     = 4'b0000;
endpackage

// File: rtl/pbm_lat_tmr.sv
`timescale 1ns/1ps
module pbm_lat_tmr #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [LAT_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tmr_q <= '0;
    else if (load_i)                 tmr_q <= lat_i;
    else if (run_i && tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign expired_o = (tmr_q == '0);

  // R4
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (expired_o == ($past(lat_i) == '0)));
endmodule

// File: rtl/pbm_beat_ctr.sv
`timescale 1ns/1ps
module pbm_beat_ctr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              beat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (beat_i) begin
      addr_q <= addr_q + ADDR_W'(STEP);
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign last_o  = (cnt_q == CNT_W'(1));
  assign empty_o = (cnt_q == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> cnt_q != '0);
  // R2
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_i && !load_i) |=> ($stable(cnt_q) && $stable(addr_q)));
endmodule

// File: rtl/pbm_fsm.sv
`timescale 1ns/1ps
module pbm_fsm
  import pbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       zero_cnt_i,
  input  logic       dreq_i,
  input  logic       gnt_ni,
  input  logic       trdy_ni,
  input  logic       stop_ni,
  input  logic       last_beat_i,
  input  logic       cnt_empty_i,
  input  logic       tmr_expired_i,
  output pbm_state_e st_o,
  output logic       req_no,
  output logic       frame_no,
  output logic       irdy_no,
  output logic       beat_o,
  output logic       done_o,
  output logic       tmr_load_o,
  output logic       ctr_load_o
);
  pbm_state_e st_q, st_d;
  logic fin_q, fin_d;
  logic done_q, done_d;
  logic in_data, final_ph, trdy_act, stop_act, grab;

  assign in_data  = (st_q == ST_DATA);
  // final phase: last beat of the transfer or a latched early ending
  assign final_ph = in_data && (last_beat_i || fin_q);
  assign trdy_act = !trdy_ni;
  assign stop_act = !stop_ni;
  assign grab     = (st_q == ST_REQ) && dreq_i && !gnt_ni;

  always_comb begin
    st_d   = st_q;
    fin_d  = fin_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (zero_cnt_i) done_d = 1'b1;
        else            st_d   = ST_REQ;
      end
      ST_REQ:  if (grab) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (final_ph) begin
          if (trdy_act || stop_act) begin
            st_d  = ST_TURN;
            fin_d = 1'b0;
          end
        end else if (stop_act || (tmr_expired_i && gnt_ni)) begin
          fin_d = 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_empty_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_REQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fin_q  <= fin_d;
      done_q <= done_d;
    end
  end

  assign st_o       = st_q;
  assign frame_no   = !((st_q == ST_ADDR) || (in_data && !final_ph));
  assign irdy_no    = !in_data;
  assign req_no     = !(((st_q == ST_REQ) && dreq_i) || (st_q == ST_ADDR) ||
                        (in_data && !final_ph));
  assign beat_o     = in_data && trdy_act;
  assign done_o     = done_q;
  assign tmr_load_o = grab;
  assign ctr_load_o = (st_q == ST_IDLE) && start_i;

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> st_q == ST_IDLE);
  // R9
  single_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && last_beat_i) |=> (frame_no && !irdy_no));
endmodule

// File: rtl/pbm_master.sv
`timescale 1ns/1ps
module pbm_master
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int LAT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  beat_count_i,
  input  logic              write_i,
  input  logic              dreq_i,
  input  logic [LAT_W-1:0]  lat_timer_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_pop_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_no,
  input  logic              gnt_ni,
  output logic              frame_no,
  output logic              irdy_no,
  input  logic              trdy_ni,
  input  logic              stop_ni,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic [3:0]        cbe_o
);
  localparam int STEP = DATA_W / 8;

  pbm_state_e        st;
  logic              beat, tmr_load, ctr_load, tmr_exp, last_beat, cnt_empty;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_q <= 1'b0;
    else if (ctr_load) wr_q <= write_i;
  end

  pbm_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .zero_cnt_i    (beat_count_i == '0),
    .dreq_i        (dreq_i),
    .gnt_ni        (gnt_ni),
    .trdy_ni       (trdy_ni),
    .stop_ni       (stop_ni),
    .last_beat_i   (last_beat),
    .cnt_empty_i   (cnt_empty),
    .tmr_expired_i (tmr_exp),
    .st_o          (st),
    .req_no        (req_no),
    .frame_no      (frame_no),
    .irdy_no       (irdy_no),
    .beat_o        (beat),
    .done_o        (done_o),
    .tmr_load_o    (tmr_load),
    .ctr_load_o    (ctr_load)
  );

  pbm_beat_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctr_load),
    .addr_i  (start_addr_i),
    .cnt_i   (beat_count_i),
    .beat_i  (beat),
    .addr_o  (cur_addr),
    .last_o  (last_beat),
    .empty_o (cnt_empty)
  );

  pbm_lat_tmr #(.LAT_W(LAT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .lat_i     (lat_timer_i),
    .run_i     ((st == ST_ADDR) || (st == ST_DATA)),
    .expired_o (tmr_exp)
  );

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    cbe_o   = BE_ALL;
    if (st == ST_ADDR) begin
      ad_o    = DATA_W'(cur_addr);
      ad_oe_o = 1'b1;
      cbe_o   = wr_q ? CMD_MEM_WR : CMD_MEM_RD;
    end else if (st == ST_DATA && wr_q) begin
      ad_o    = wr_data_i;
      ad_oe_o = 1'b1;
    end
  end

  assign wr_pop_o   = beat && wr_q;
  assign rd_valid_o = beat && !wr_q;
  assign rd_data_o  = ad_i;
  assign busy_o     = (st != ST_IDLE);

  // R8
  frame_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> !irdy_no);
  // R8
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irdy_no) |-> (frame_no && req_no && !ad_oe_o));
  // R7
  cmd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> (irdy_no && (cbe_o == CMD_MEM_RD || cbe_o == CMD_MEM_WR)));
  // R10
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_no) |-> dreq_i);
  // R12
  pop_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pop_o || rd_valid_o) |-> (!irdy_no && !trdy_ni));
endmodule

// File: tb/tb_pbm_master.sv
`timescale 1ns/1ps
module tb_pbm_master;
  localparam logic [31:0] WBASE = 32'hA500_0000;
  localparam logic [31:0] RBASE = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [31:0] beat_count_i = '0;
  logic        write_i = 1'b0;
  logic        dreq_i = 1'b1;
  logic [7:0]  lat_timer_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_pop_o, rd_valid_o, busy_o, done_o;
  logic [31:0] rd_data_o, ad_o;
  logic        req_no, frame_no, irdy_no, ad_oe_o;
  logic        gnt_ni = 1'b1, trdy_ni = 1'b1, stop_ni = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_o;

  always #10 clk = !clk;

  pbm_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .beat_count_i(beat_count_i), .write_i(write_i), .dreq_i(dreq_i),
    .lat_timer_i(lat_timer_i), .wr_data_i(wr_data_i), .wr_pop_o(wr_pop_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
    .done_o(done_o), .req_no(req_no), .gnt_ni(gnt_ni), .frame_no(frame_no),
    .irdy_no(irdy_no), .trdy_ni(trdy_ni), .stop_ni(stop_ni), .ad_o(ad_o),
    .ad_i(ad_i), .ad_oe_o(ad_oe_o), .cbe_o(cbe_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // scenario settings
  logic [31:0] base;
  int  exp_total;
  bit  wr_mode, strict, wait_mode, stop_data, stop_armed;
  int  gnt_mode, stop_at;
  // monitor results
  int  total_beats, n_ten, ten_cnt, waits_seen;
  int  addr_err, data_err, frame_err, turn_err, req_seen;
  logic [31:0] ten_addr [16];
  logic [3:0]  ten_cmd [16];
  int          ten_beats [16];
  bit          ten_single [16];
  bit stop_pend, wait_tog, prev_data, first_dp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    total_beats = 0; n_ten = 0; ten_cnt = 0; waits_seen = 0;
    addr_err = 0; data_err = 0; frame_err = 0; turn_err = 0; req_seen = 0;
    for (int i = 0; i < 16; i++) begin
      ten_addr[i] = '0; ten_cmd[i] = '0; ten_beats[i] = 0; ten_single[i] = 0;
    end
  endtask

  // target and arbiter model, evaluated mid-cycle
  initial begin
    clear_stats();
    stop_pend = 0; wait_tog = 1; prev_data = 0; first_dp = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (gnt_mode == 1 && (!frame_no || !irdy_no)) gnt_ni = 1'b1;
        else gnt_ni = req_no;
        ad_i = RBASE ^ 32'(total_beats);
        if (!irdy_no) begin
          if (stop_pend) begin
            stop_ni = 1'b0; trdy_ni = 1'b1;
          end else if (stop_armed && ten_cnt == stop_at) begin
            stop_ni = 1'b0; trdy_ni = !stop_data;
            stop_pend = 1; stop_armed = 0;
          end else begin
            stop_ni = 1'b1;
            if (wait_mode) begin trdy_ni = wait_tog; wait_tog = !wait_tog; end
            else trdy_ni = 1'b0;
          end
        end else begin
          trdy_ni = 1'b1; stop_ni = 1'b1; stop_pend = 0; wait_tog = 1;
        end
        #1;
        if (!req_no) req_seen++;
        if (!frame_no && irdy_no && n_ten < 16) begin
          ten_addr[n_ten] = ad_o; ten_cmd[n_ten] = cbe_o; ten_beats[n_ten] = 0;
          if (ad_o != base + 32'(4 * total_beats) || !ad_oe_o) addr_err++;
          n_ten++; ten_cnt = 0; first_dp = 1;
        end
        if (!irdy_no) begin
          if (first_dp && n_ten > 0) ten_single[n_ten-1] = frame_no;
          first_dp = 0;
          if (strict && (frame_no != (total_beats == exp_total - 1))) frame_err++;
          if (cbe_o != 4'b0000) data_err++;
          if (!trdy_ni) begin
            if (wr_mode) begin
              if (!wr_pop_o || rd_valid_o || !ad_oe_o ||
                  ad_o != WBASE + 32'(total_beats)) data_err++;
            end else begin
              if (!rd_valid_o || wr_pop_o || ad_oe_o || rd_data_o != ad_i) data_err++;
            end
            total_beats++; ten_cnt++;
            if (n_ten > 0) ten_beats[n_ten-1] = ten_cnt;
          end else begin
            waits_seen++;
            if (wr_pop_o || rd_valid_o) data_err++;
          end
        end
        if (prev_data && irdy_no && (!frame_no || ad_oe_o || !req_no)) turn_err++;
        prev_data = !irdy_no;
        wr_data_i = WBASE + 32'(total_beats);
      end
    end
  end

  task automatic run_xfer(input logic [31:0] a, input int n, input bit w,
                          input int lat, input int gm, input bit wm,
                          input int sa, input bit sd);
    int cyc;
    @(posedge clk); #2;
    clear_stats();
    base = a; exp_total = n; wr_mode = w; gnt_mode = gm; wait_mode = wm;
    stop_at = sa; stop_data = sd; stop_armed = (sa >= 0);
    strict = (sa < 0) && (gm == 0);
    start_addr_i = a; beat_count_i = 32'(n); write_i = w;
    lat_timer_i = 8'(lat); dreq_i = 1'b1; start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    cyc = 0;
    do begin @(negedge clk); #2; cyc++; end while (!done_o && cyc < 3000);
    chk(done_o, "R11 done pulse seen", 32'(done_o), 1);
    @(negedge clk); #2;
    chk(!done_o && !busy_o, "R11 done one cycle then idle", {busy_o, done_o}, 0);
    chk(total_beats == n, "R11 total beats moved", 32'(total_beats), 32'(n));
  endtask

  task automatic t_reset();
    chk(req_no && frame_no && irdy_no, "R1 bus idle in reset", {req_no, frame_no, irdy_no}, 3'b111);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk); #2;
    chk(req_no && frame_no && irdy_no && !ad_oe_o, "R1 bus idle after reset",
        {req_no, frame_no, irdy_no, ad_oe_o}, 4'b1110);
    chk(!busy_o && !done_o, "R1 busy/done low", {busy_o, done_o}, 0);
  endtask

  task automatic t_single_write();
    run_xfer(32'h0000_1000, 1, 1, 8, 0, 0, -1, 0);
    chk(n_ten == 1, "R9 one tenure", 32'(n_ten), 1);
    chk(ten_single[0], "R9 frame released at first irdy", 32'(ten_single[0]), 1);
    chk(ten_cmd[0] == 4'b0111, "R7 write command", 32'(ten_cmd[0]), 32'h7);
    chk(ten_addr[0] == 32'h0000_1000, "R7 address phase", ten_addr[0], 32'h1000);
    chk(data_err == 0, "R12 write data", 32'(data_err), 0);
    chk(turn_err == 0, "R8 turnaround", 32'(turn_err), 0);
  endtask

  task automatic t_read_burst();
    run_xfer(32'h0002_0040, 8, 0, 2, 0, 0, -1, 0);
    chk(n_ten == 1 && ten_beats[0] == 8, "R3 single 8-beat tenure", 32'(ten_beats[0]), 8);
    chk(ten_cmd[0] == 4'b0110, "R7 read command", 32'(ten_cmd[0]), 32'h6);
    chk(frame_err == 0, "R8 frame only on final phase", 32'(frame_err), 0);
    chk(data_err == 0, "R12 read data passthrough", 32'(data_err), 0);
    chk(turn_err == 0, "R8 turnaround after read", 32'(turn_err), 0);
  endtask

  task automatic t_wait_write();
    run_xfer(32'h0000_3000, 6, 1, 4, 0, 1, -1, 0);
    chk(waits_seen >= 6, "R2 wait states occurred", 32'(waits_seen), 6);
    chk(data_err == 0, "R2 no advance on wait", 32'(data_err), 0);
    chk(frame_err == 0, "R8 frame with waits", 32'(frame_err), 0);
  endtask

  task automatic t_grant_held();
    run_xfer(32'h0001_0000, 20, 0, 3, 0, 0, -1, 0);
    chk(n_ten == 1, "R3 no cap with grant held", 32'(n_ten), 1);
    chk(ten_beats[0] == 20, "R3 all beats in one burst", 32'(ten_beats[0]), 20);
  endtask

  task automatic t_latency();
    run_xfer(32'h0004_0000, 20, 1, 3, 1, 0, -1, 0);
    chk(ten_beats[0] == 4, "R4 first tenure lat+1 beats", 32'(ten_beats[0]), 4);
    chk(n_ten == 5, "R4 tenure count", 32'(n_ten), 5);
    chk(ten_addr[1] == 32'h0004_0010, "R6 resume address", ten_addr[1], 32'h0004_0010);
    chk(addr_err == 0 && data_err == 0, "R6 addresses and data", 32'(addr_err + data_err), 0);
    chk(turn_err == 0, "R8 req dropped at each end", 32'(turn_err), 0);
  endtask

  task automatic t_stop_data();
    run_xfer(32'h0005_0000, 10, 0, 8, 0, 0, 2, 1);
    chk(n_ten == 2, "R5 stop splits transfer", 32'(n_ten), 2);
    chk(ten_beats[0] == 3, "R5 stop with trdy counts", 32'(ten_beats[0]), 3);
    chk(ten_beats[1] == 7, "R6 remainder after re-arbitration", 32'(ten_beats[1]), 7);
    chk(ten_addr[1] == 32'h0005_000C, "R6 next address", ten_addr[1], 32'h0005_000C);
    chk(data_err == 0, "R5 data across disconnect", 32'(data_err), 0);
  endtask

  task automatic t_retry();
    run_xfer(32'h0006_0100, 4, 1, 8, 0, 0, 0, 0);
    chk(ten_beats[0] == 0, "R5 retry moves no data", 32'(ten_beats[0]), 0);
    chk(ten_addr[1] == ten_addr[0], "R6 retried address repeated", ten_addr[1], ten_addr[0]);
    chk(n_ten == 2 && ten_beats[1] == 4, "R6 retry completes", 32'(ten_beats[1]), 4);
  endtask

  task automatic t_dreq_gate();
    int cyc;
    @(posedge clk); #2;
    clear_stats();
    base = 32'h0007_0000; exp_total = 2; wr_mode = 1; gnt_mode = 0; wait_mode = 0;
    stop_armed = 0; strict = 1;
    start_addr_i = base; beat_count_i = 2; write_i = 1; lat_timer_i = 8;
    dreq_i = 1'b0; start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    chk(req_no && busy_o && req_seen == 0, "R10 no request without demand",
        {req_no, busy_o}, 2'b11);
    @(posedge clk); #2; dreq_i = 1'b1;
    cyc = 0;
    do begin @(negedge clk); #2; cyc++; end while (!done_o && cyc < 3000);
    chk(done_o && total_beats == 2, "R10 runs once demand rises", 32'(total_beats), 2);
  endtask

  task automatic t_zero();
    @(posedge clk); #2;
    clear_stats();
    beat_count_i = '0; start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    @(negedge clk); #2;
    chk(done_o, "R11 zero count done", 32'(done_o), 1);
    @(negedge clk); #2;
    chk(!done_o && req_seen == 0 && n_ten == 0, "R11 zero count no bus use",
        32'(req_seen + n_ten), 0);
  endtask

  initial begin
    base = '0; exp_total = 0; wr_mode = 0; strict = 0; wait_mode = 0;
    stop_data = 0; stop_armed = 0; gnt_mode = 0; stop_at = -1;
    repeat (3) @(posedge clk);
    t_reset();
    t_single_write();
    t_read_burst();
    t_wait_write();
    t_grant_held();
    t_latency();
    t_stop_data();
    t_retry();
    t_dreq_gate();
    t_zero();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule